// File: doc/BRIEF.md
# Windowed watchdog reset controller

This block supervises a processor through two inputs: a voltage-good flag from an external comparator and a single service line that the software toggles. It drives an active-low processor reset and an active-low enable for critical loads. After the voltage flag rises, reset is held for a power-on delay. The block then runs repeating cycles, each made of a closed window and then an open window.

A service edge is accepted only inside the open window. An edge in the closed window is a fault, and a missing edge is also a fault. Each fault produces a short reset pulse and starts a new cycle. The enable output stays inactive until the software has produced enough consecutive good services. A loss of voltage overrides everything else.

All durations are counted in strobes of an external time-base enable `tick_i`. Each strobe stands for half of a nominal tick, so a pulse of 2.5 ticks is the integer value 5.

Top module: `wdog_win_ctrl`

## Requirements
- R1: While `rst_ni` is low, and while the filtered voltage flag is low, `rst_no` is 0 and `en_no` is 1.
- R2: `rst_no` rises 3 clocks plus POR_HT strobes after `vgood_i` rises. The 3 clocks are two synchronizer flops and one filter flop. POR_HT equals WD_HT, or WD_HT/4 when POR_QUARTER=1. Service edges during this delay have no effect.
- R3: Each cycle has a closed window followed by an open window. With RATIO_SEL=0 the closed window is WIN_HT minus WIN_HT/3 strobes and the open window is the rest. With RATIO_SEL=1 the closed window is WIN_HT/3. A service is a rising edge of `svc_i`, and it is acted on at the 3rd clock edge after it is sampled.
- R4: A service that acts while the open window is active starts a new closed window, and `rst_no` stays 1.
- R5: A service that acts while the closed window is active drives `rst_no` to 0 for PULSE_HT strobes. A new closed window follows.
- R6: With no service, `rst_no` is 1 for closed plus open strobes and then 0 for PULSE_HT strobes. This repeats as a square wave.
- R7: When a service acts on the same clock as the last strobe of a window, the service decides the outcome, not the window expiry.
- R8: `vgood_i` low for GLITCH_CLKS consecutive synchronized clocks forces `rst_no` to 0 and `en_no` to 1. A fresh R2 delay follows. Shorter lows are ignored, and services during the drop have no effect.
- R9: `en_no` goes to 0 only while `rst_no` is 1 and after 3 consecutive open-window services. The count saturates at 3. A closed-window service, a timeout or a voltage drop clears the count.
- R10: Every window, delay and pulse advances only on clocks where `tick_i` is 1. Clocks with `tick_i` at 0 lengthen the current interval by the same number of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one strobe per half tick |
| vgood_i | input | 1 | Asynchronous voltage-good flag |
| svc_i | input | 1 | Asynchronous service line, rising edge services |
| rst_no | output | 1 | Active-low processor reset |
| en_no | output | 1 | Active-low enable for critical loads |

## Verification
A service and the expiry of the current window can land on the same clock edge. The bench provokes this by timing a service so that it acts on the final strobe of the closed window, and again on the final strobe of the open window. In both cases the outcome is judged against R7: the early service must still fault, and the late service must still be accepted, with `rst_no` and `en_no` sampled just after the deciding edge. A voltage drop that overlaps a pending service is also covered: the service must leave reset low and enable inactive.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_POR    = 2'd0,
    ST_CLOSED = 2'd1,
    ST_OPEN   = 2'd2,
    ST_PULSE  = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CW = STAGES * WIDTH;

  logic [CW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CW-WIDTH-1:0], d_i};
  end

  assign q_o = chain_q[CW-1 -: WIDTH];
endmodule

// File: rtl/wdog_drop_filt.sv
module wdog_drop_filt #(
  parameter int GLITCH_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vg_i,
  output logic vok_o
);
  localparam int GW = $clog2(GLITCH_CLKS + 1);
  localparam logic [GW-1:0] LOW_LAST = GW'(GLITCH_CLKS - 1);

  logic [GW-1:0] low_cnt_q;
  logic          vok_q;

  // rise passes at once; fall needs GLITCH_CLKS consecutive low samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vok_q     <= 1'b0;
      low_cnt_q <= '0;
    end else if (vg_i) begin
      vok_q     <= 1'b1;
      low_cnt_q <= '0;
    end else if (vok_q) begin
      if (low_cnt_q == LOW_LAST) begin
        vok_q     <= 1'b0;
        low_cnt_q <= '0;
      end else begin
        low_cnt_q <= low_cnt_q + 1'b1;
      end
    end
  end

  assign vok_o = vok_q;
endmodule

// File: rtl/wdog_win_fsm.sv
module wdog_win_fsm
  import wdog_pkg::*;
#(
  parameter int POR_HT    = 200,
  parameter int CLOSED_HT = 160,
  parameter int OPEN_HT   = 80,
  parameter int PULSE_HT  = 5
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      vok_i,
  input  logic      svc_edge_i,
  output wd_state_e state_o,
  output logic      rst_no
);
  localparam int M1    = (POR_HT > CLOSED_HT) ? POR_HT : CLOSED_HT;
  localparam int M2    = (OPEN_HT > PULSE_HT) ? OPEN_HT : PULSE_HT;
  localparam int MAXL  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam logic [CNT_W-1:0] POR_LAST    = CNT_W'(POR_HT - 1);
  localparam logic [CNT_W-1:0] CLOSED_LAST = CNT_W'(CLOSED_HT - 1);
  localparam logic [CNT_W-1:0] OPEN_LAST   = CNT_W'(OPEN_HT - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_HT - 1);

  wd_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!vok_i) begin
      st_d  = ST_POR;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_POR: begin
          if (tick_i) begin
            if (cnt_q == POR_LAST) begin st_d = ST_CLOSED; cnt_d = '0; end
            else cnt_d = cnt_q + 1'b1;
          end
        end
        ST_CLOSED: begin
          if (svc_edge_i) begin
            st_d  = ST_PULSE;   // too early
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_q == CLOSED_LAST) begin st_d = ST_OPEN; cnt_d = '0; end
            else cnt_d = cnt_q + 1'b1;
          end
        end
        ST_OPEN: begin
          if (svc_edge_i) begin
            st_d  = ST_CLOSED;  // good service wins over expiry
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_q == OPEN_LAST) begin st_d = ST_PULSE; cnt_d = '0; end
            else cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PULSE: begin
          if (tick_i) begin
            if (cnt_q == PULSE_LAST) begin st_d = ST_CLOSED; cnt_d = '0; end
            else cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = ST_POR;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_POR;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign rst_no  = (st_q == ST_CLOSED) || (st_q == ST_OPEN);
endmodule

// File: rtl/wdog_en_qual.sv
module wdog_en_qual #(
  parameter int GOOD_NEED = 3,
  localparam int CW = $clog2(GOOD_NEED + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          good_i,
  input  logic          clr_i,
  input  logic          rst_act_i,
  output logic [CW-1:0] cnt_o,
  output logic          en_no
);
  localparam logic [CW-1:0] FULL = CW'(GOOD_NEED);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (good_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign en_no = !((cnt_q == FULL) && !rst_act_i);
endmodule

// File: rtl/wdog_win_ctrl.sv
module wdog_win_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN_HT      = 240,  // closed + open, half ticks
  parameter bit RATIO_SEL   = 1'b0, // 0: long closed, 1: long open
  parameter int PULSE_HT    = 5,
  parameter int WD_HT       = 200,
  parameter bit POR_QUARTER = 1'b0,
  parameter int GLITCH_CLKS = 4,
  parameter int GOOD_NEED   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vgood_i,
  input  logic svc_i,
  output logic rst_no,
  output logic en_no
);
  localparam int CLOSED_HT = RATIO_SEL ? (WIN_HT / 3) : (WIN_HT - WIN_HT / 3);
  localparam int OPEN_HT   = WIN_HT - CLOSED_HT;
  localparam int POR_HT    = POR_QUARTER ? (WD_HT / 4) : WD_HT;
  localparam int GOOD_W    = $clog2(GOOD_NEED + 1);

  logic              vg_s, svc_s, svc_d_q, svc_edge, vok;
  logic              rst_n_int;
  wd_state_e         state;
  logic [GOOD_W-1:0] good_cnt;

  wdog_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vgood_i, svc_i}),
    .q_o   ({vg_s, svc_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_d_q <= 1'b0;
    else         svc_d_q <= svc_s;
  end
  assign svc_edge = svc_s & ~svc_d_q;

  wdog_drop_filt #(.GLITCH_CLKS(GLITCH_CLKS)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vg_i  (vg_s),
    .vok_o (vok)
  );

  wdog_win_fsm #(
    .POR_HT   (POR_HT),
    .CLOSED_HT(CLOSED_HT),
    .OPEN_HT  (OPEN_HT),
    .PULSE_HT (PULSE_HT)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .vok_i     (vok),
    .svc_edge_i(svc_edge),
    .state_o   (state),
    .rst_no    (rst_n_int)
  );

  wdog_en_qual #(.GOOD_NEED(GOOD_NEED)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .good_i   ((state == ST_OPEN) && svc_edge && vok),
    .clr_i    ((state == ST_POR) || (state == ST_PULSE)),
    .rst_act_i(!rst_n_int),
    .cnt_o    (good_cnt),
    .en_no    (en_no)
  );

  assign rst_no = rst_n_int;
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk
  import wdog_pkg::*;
#(
  parameter int GOOD_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vok_i,
  input wd_state_e         state_i,
  input logic              svc_edge_i,
  input logic [GOOD_W-1:0] good_cnt_i,
  input logic              rst_no,
  input logic              en_no
);
  assert_vdrop_forces_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vok_i |=> !rst_no);

  assert_en_off_in_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> en_no);

  assert_early_service_faults_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CLOSED) && svc_edge_i |=> !rst_no);

  assert_open_service_keeps_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OPEN) && svc_edge_i && vok_i |=> rst_no);

  assert_fault_clears_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PULSE) |=> (good_cnt_i == '0));

  assert_en_needs_good_service_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_no) |-> $past((state_i == ST_OPEN) && svc_edge_i));

  assert_reset_while_por_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_POR) |-> !rst_no);
endmodule

bind wdog_win_ctrl wdog_win_chk #(.GOOD_W(GOOD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vok_i     (vok),
  .state_i   (state),
  .svc_edge_i(svc_edge),
  .good_cnt_i(good_cnt),
  .rst_no    (rst_no),
  .en_no     (en_no)
);

// File: tb/wdog_win_ctrl_tb_top.sv
module wdog_win_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic vgood = 1'b0;
  logic svc = 1'b0;
  logic svc_q = 1'b0;
  logic rst_no, en_no, rst_q_no, en_q_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  // WIN 12 -> closed 8 / open 4, pulse 2, POR 8
  wdog_win_ctrl #(.WIN_HT(12), .RATIO_SEL(1'b0), .PULSE_HT(2), .WD_HT(8),
                  .POR_QUARTER(1'b0), .GLITCH_CLKS(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .vgood_i(vgood),
    .svc_i(svc), .rst_no(rst_no), .en_no(en_no));

  // closed 4 / open 8, POR 2
  wdog_win_ctrl #(.WIN_HT(12), .RATIO_SEL(1'b1), .PULSE_HT(2), .WD_HT(8),
                  .POR_QUARTER(1'b1), .GLITCH_CLKS(3)) dut_q (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .vgood_i(vgood),
    .svc_i(svc_q), .rst_no(rst_q_no), .en_no(en_q_no));

  typedef struct packed {
    logic [7:0] d;
    logic       r;
    logic       e;
  } vec_t;

  // d = negedges after window start before driving the service
  localparam vec_t VEC [11] = '{
    '{8'd7, 1'b1, 1'b1},  // R4 good 1
    '{8'd7, 1'b1, 1'b1},  // R4 good 2
    '{8'd7, 1'b1, 1'b0},  // R9 good 3 -> enable
    '{8'd6, 1'b1, 1'b0},  // R4 first open strobe, R9 saturated
    '{8'd9, 1'b1, 1'b0},  // R7 service on last open strobe
    '{8'd5, 1'b0, 1'b1},  // R7 service on last closed strobe faults
    '{8'd7, 1'b1, 1'b1},
    '{8'd0, 1'b0, 1'b1},  // R5 clearly early
    '{8'd7, 1'b1, 1'b1},
    '{8'd7, 1'b1, 1'b1},
    '{8'd7, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_svc(input int d, input bit use_q);
    repeat (d) @(negedge clk);
    if (use_q) svc_q = 1'b1; else svc = 1'b1;
    @(negedge clk);
    if (use_q) svc_q = 1'b0; else svc = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_rise(input bit use_q);
    while ((use_q ? rst_q_no : rst_no) == 1'b1) @(negedge clk);
    while ((use_q ? rst_q_no : rst_no) == 1'b0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nm, nq, hi, lo;
    bit ok;
    repeat (3) @(negedge clk);
    check("R1 rst in reset", rst_no, 0);
    check("R1 en in reset", en_no, 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 rst while voltage low", rst_no, 0);

    // R2: power-on delay, service during it ignored
    vgood = 1'b1;
    nm = 0; nq = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n == 3) svc = 1'b1;
      if (n == 4) svc = 1'b0;
      if (rst_no && nm == 0) nm = n;
      if (rst_q_no && nq == 0) nq = n;
      if (nm != 0 && nq != 0) break;
    end
    check("R2 por release full", nm, 11);
    check("R2 por release quarter", nq, 5);
    check("R9 en after por", en_no, 1);

    // R3/R4/R5/R7/R9 vector walk
    foreach (VEC[i]) begin
      pulse_svc(int'(VEC[i].d), 1'b0);
      check($sformatf("R4/R5 vec %0d rst", i), rst_no, VEC[i].r);
      check($sformatf("R9 vec %0d en", i), en_no, VEC[i].e);
      if (!VEC[i].r) wait_rise(1'b0);
    end

    // R6 timeout square wave, R10 tick gating
    hi = 0;
    while (rst_no) begin @(negedge clk); hi++; end
    check("R6 high run", hi, 12);
    lo = 0;
    while (!rst_no) begin @(negedge clk); lo++; end
    check("R6 low pulse", lo, 2);
    check("R9 en cleared by timeout", en_no, 1);
    tick = 1'b0;
    hi = 0;
    while (rst_no) begin
      @(negedge clk);
      hi++;
      if (hi == 5) tick = 1'b1;
    end
    check("R10 gated high run", hi, 17);
    while (!rst_no) @(negedge clk);

    // R8 short glitch ignored
    vgood = 1'b0;
    @(negedge clk);
    @(negedge clk);
    vgood = 1'b1;
    ok = 1'b1;
    repeat (5) begin @(negedge clk); if (!rst_no) ok = 1'b0; end
    check("R8 glitch filtered", ok, 1);

    // R8 real drop with service during it
    vgood = 1'b0;
    repeat (3) @(negedge clk);
    svc = 1'b1;
    @(negedge clk);
    svc = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 rst on drop", rst_no, 0);
    check("R8 en on drop", en_no, 1);
    vgood = 1'b1;
    nm = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (rst_no) begin nm = n; break; end
    end
    check("R2 fresh por after drop", nm, 11);
    pulse_svc(7, 1'b0);
    check("R9 en needs 3 after drop", en_no, 1);
    check("R4 service after drop", rst_no, 1);

    // R3 wide-open ratio on second instance
    wait_rise(1'b1);
    pulse_svc(2, 1'b1);
    check("R3 wide open accepts", rst_q_no, 1);
    pulse_svc(0, 1'b1);
    check("R3 wide open closed faults", rst_q_no, 0);

    finish_run();
  end
endmodule